// File: doc/BRIEF.md
# Master Abort Error Handler

This block watches an address translation unit acting as initiator on a conventional PCI or PCI-X bus. It notices when a transaction is never claimed and then carries out the error-reporting work. Abort events come from two places. The first is a local timeout: after FRAME# is first sampled asserted, no target drives DEVSEL# within a window whose length depends on the bus mode. The second is a decoded split completion error message, sent by a bridge, whose class and index fields mark a master abort on the far side of that bridge.

Both sources feed one action stage. That stage sets sticky status bits and sets interrupt-status bits only where the mask and enable inputs allow. For a write-type failure it decides whether to pulse SERR#. It also issues flush requests toward the data and address queues. When the failed request was an outbound read, it sends an error completion toward the internal bus. Software clears the status bits by writing ones to them.

Top module: `master_abort_handler`

## Requirements
- R1: After FRAME# is first sampled low, DEVSEL# sampled low on any of the next 5 clocks (conventional mode, `pcix_mode`=0) or the next 7 clocks (PCI-X mode) means no abort. If DEVSEL# is still high on the last of those clocks, an abort is declared, and its outputs appear on the following clock edge.
- R2: A split completion error message counts as an abort only in PCI-X mode and only with class 1h and index 00h. A message with any other class or index, or any message in conventional mode, changes no output.
- R3: Every abort sets status bit 13 of `sts_word`. The bit stays set until a one is written to it through `sts_clr[13]`. All status bits in `sts_word` clear only through their own bit of `sts_clr`.
- R4: An abort sets `irq_sts[0]` only when `mask_abort` is 0. Raising the mask later does not clear a bit that is already set. `irq_sts` bits clear only through a one in `irq_clr`.
- R5: An abort of kind outbound write (1), outbound MSI write (2) or inbound completion (3) gives exactly one one-clock `flush_data` pulse. An outbound read (0) gives none.
- R6: An abort of any outbound kind (0, 1, 2) gives exactly one one-clock `flush_otq` pulse. An inbound completion gives none.
- R7: An aborted MSI write with `serr_enable`=1 drives `serr_n` low for exactly one clock and sets status bit 14 of `sts_word`. Without `serr_enable`, or for any other kind, `serr_n` stays high.
- R8: When SERR# is pulsed, `irq_sts[1]` is set if `mask_serr` is 0, and `irq_sts[2]` is set if `serr_detect_en` is 1.
- R9: An abort reported by message sets `scm_sts`, and sets `irq_sts[3]` if `mask_scm` is 0. The message's own kind (`msg_kind`) selects the flush, SERR# and completion actions, and the actions appear one clock after the message is sampled.
- R10: An aborted outbound read gives exactly one one-clock `cpl_err_valid` pulse with `cpl_err_class`=1h and `cpl_err_index`=00h.
- R11: When a timeout abort and a valid message are detected on the same clock, the timeout is acted on first and the message on the next clock, so neither event is lost.
- R12: After reset, all status and interrupt bits are 0, `serr_n` is 1 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcix_mode | input | 1 | 1 selects the PCI-X timeout window, 0 the conventional one |
| frame_n | input | 1 | Sampled FRAME#, active low |
| devsel_n | input | 1 | Sampled DEVSEL#, active low |
| bus_kind | input | 2 | Kind of the transaction on the bus: 0 outbound read, 1 outbound write, 2 outbound MSI write, 3 inbound completion |
| msg_valid | input | 1 | One-clock strobe of a decoded split completion error message |
| msg_class | input | 4 | Class field of the message |
| msg_index | input | 8 | Index field of the message |
| msg_kind | input | 2 | Kind of the split request the message refers to, same coding as `bus_kind` |
| serr_enable | input | 1 | SERR# enable command bit |
| serr_detect_en | input | 1 | Enable for the SERR#-detected interrupt bit |
| mask_abort | input | 1 | Mask for the abort interrupt bit |
| mask_serr | input | 1 | Mask for the SERR#-asserted interrupt bit |
| mask_scm | input | 1 | Mask for the message-error interrupt bit |
| sts_clr | input | 16 | Write-one-to-clear strobes for `sts_word` |
| scm_sts_clr | input | 1 | Write-one-to-clear strobe for `scm_sts` |
| irq_clr | input | 4 | Write-one-to-clear strobes for `irq_sts` |
| sts_word | output | 16 | Status word: bit 13 abort, bit 14 SERR# asserted |
| scm_sts | output | 1 | Split completion error message received |
| irq_sts | output | 4 | Interrupt status: 0 abort, 1 SERR# asserted, 2 SERR# detected, 3 message error |
| serr_n | output | 1 | SERR#, active-low one-clock pulse |
| flush_data | output | 1 | One-clock request to flush data and address of the failed transfer |
| flush_otq | output | 1 | One-clock request to drop the address from the outbound transaction queue |
| cpl_err_valid | output | 1 | One-clock strobe of an error completion toward the internal bus |
| cpl_err_class | output | 4 | Class of the error completion |
| cpl_err_index | output | 8 | Index of the error completion |

## Verification
The assertions assume well-formed bus sampling. DEVSEL# is never low before FRAME# starts a transaction, FRAME# stays low until the claim or the abort has been seen, and `bus_kind` holds steady through the transaction. They also assume that message strobes are at least two clocks apart and that masks and enables do not change in the clock when an event is acted on. The bench keeps within these rules: it runs one transaction at a time with an idle clock before and after, raises DEVSEL# only after FRAME#, and places at most one single-clock message inside a transaction window. It changes masks only between transactions.

// File: rtl/mah_pkg.sv
package mah_pkg;

  typedef enum logic [1:0] {
    TK_OUT_READ  = 2'd0,
    TK_OUT_WRITE = 2'd1,
    TK_OUT_MSI   = 2'd2,
    TK_IN_CPL    = 2'd3
  } txn_kind_e;

  localparam int IRQ_W         = 4;
  localparam int IRQ_ABORT     = 0;
  localparam int IRQ_SERR_ASRT = 1;
  localparam int IRQ_SERR_DET  = 2;
  localparam int IRQ_SCM       = 3;

  // Number of clocks after the FRAME# edge in which a claim is accepted.
  function automatic int claim_window(input logic pcix, input int conv_clks,
                                      input int pcix_clks);
    return pcix ? pcix_clks : conv_clks;
  endfunction

  // Does a message carry the bridge master-abort code?
  function automatic logic code_matches(input logic [31:0] cls, input logic [31:0] idx,
                                        input logic [31:0] want_cls,
                                        input logic [31:0] want_idx);
    return (cls == want_cls) && (idx == want_idx);
  endfunction

  function automatic logic wants_data_flush(input txn_kind_e k);
    return k != TK_OUT_READ;
  endfunction

  function automatic logic wants_queue_flush(input txn_kind_e k);
    return k != TK_IN_CPL;
  endfunction

  function automatic logic wants_error_cpl(input txn_kind_e k);
    return k == TK_OUT_READ;
  endfunction

  function automatic logic may_raise_serr(input txn_kind_e k, input logic enable);
    return (k == TK_OUT_MSI) && enable;
  endfunction

endpackage

// File: rtl/mah_devsel_timer.sv
module mah_devsel_timer
  import mah_pkg::*;
#(
  parameter int CONV_CLKS = 5,
  parameter int PCIX_CLKS = 7,
  parameter int CNT_W     = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pcix_mode,
  input  logic      frame_n,
  input  logic      devsel_n,
  input  txn_kind_e kind_i,
  output logic      abort_o,
  output txn_kind_e kind_o
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} tmr_state_e;

  tmr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  txn_kind_e        kind_q;
  logic             abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      kind_q  <= TK_OUT_READ;
      abort_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (!frame_n) begin
            st_q   <= S_WAIT;
            cnt_q  <= CNT_W'(1);
            lim_q  <= CNT_W'(claim_window(pcix_mode, CONV_CLKS, PCIX_CLKS));
            kind_q <= kind_i;
          end
        end
        S_WAIT: begin
          if (!devsel_n) begin
            st_q <= S_HOLD;
          end else if (cnt_q >= lim_q) begin
            abort_q <= 1'b1;
            st_q    <= S_HOLD;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_HOLD: begin
          if (frame_n && devsel_n) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign abort_o = abort_q;
  assign kind_o  = kind_q;

endmodule

// File: rtl/mah_msg_filter.sv
module mah_msg_filter
  import mah_pkg::*;
#(
  parameter int CLS_W     = 4,
  parameter int IDX_W     = 8,
  parameter int ABORT_CLS = 1,
  parameter int ABORT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcix_mode,
  input  logic             msg_valid,
  input  logic [CLS_W-1:0] msg_class,
  input  logic [IDX_W-1:0] msg_index,
  input  txn_kind_e        msg_kind,
  input  logic             take_i,
  output logic             hit_o,
  output logic             pend_o,
  output txn_kind_e        kind_o
);

  logic      pend_q;
  txn_kind_e kind_q;

  assign hit_o = msg_valid && pcix_mode &&
                 code_matches(32'(msg_class), 32'(msg_index),
                              32'(ABORT_CLS), 32'(ABORT_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= TK_OUT_READ;
    end else if (hit_o) begin
      pend_q <= 1'b1;
      kind_q <= msg_kind;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign kind_o = kind_q;

endmodule

// File: rtl/mah_action.sv
module mah_action
  import mah_pkg::*;
#(
  parameter int STS_W     = 16,
  parameter int ABORT_BIT = 13,
  parameter int SERR_BIT  = 14,
  parameter int CLS_W     = 4,
  parameter int IDX_W     = 8,
  parameter int ABORT_CLS = 1,
  parameter int ABORT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_evt,
  input  txn_kind_e        bus_kind,
  input  logic             msg_pend,
  input  txn_kind_e        msg_kind,
  output logic             msg_take,
  input  logic             serr_enable,
  input  logic             serr_detect_en,
  input  logic             mask_abort,
  input  logic             mask_serr,
  input  logic             mask_scm,
  input  logic [STS_W-1:0] sts_clr,
  input  logic             scm_sts_clr,
  input  logic [IRQ_W-1:0] irq_clr,
  output logic [STS_W-1:0] sts_word,
  output logic             scm_sts,
  output logic [IRQ_W-1:0] irq_sts,
  output logic             serr_n,
  output logic             flush_data,
  output logic             flush_otq,
  output logic             cpl_err_valid,
  output logic [CLS_W-1:0] cpl_err_class,
  output logic [IDX_W-1:0] cpl_err_index
);

  logic             act;
  logic             from_msg;
  txn_kind_e        kind;
  logic             serr_fire;
  logic [STS_W-1:0] sts_set;
  logic [IRQ_W-1:0] irq_set;
  logic [STS_W-1:0] sts_q;
  logic             scm_q;
  logic [IRQ_W-1:0] irq_q;

  // Bus timeout wins a tie; a pending message waits one clock.
  always_comb begin
    act       = bus_evt || msg_pend;
    from_msg  = !bus_evt && msg_pend;
    kind      = bus_evt ? bus_kind : msg_kind;
    msg_take  = from_msg;
    serr_fire = act && may_raise_serr(kind, serr_enable);

    sts_set            = '0;
    sts_set[ABORT_BIT] = act;
    sts_set[SERR_BIT]  = serr_fire;

    irq_set                = '0;
    irq_set[IRQ_ABORT]     = act && !mask_abort;
    irq_set[IRQ_SERR_ASRT] = serr_fire && !mask_serr;
    irq_set[IRQ_SERR_DET]  = serr_fire && serr_detect_en;
    irq_set[IRQ_SCM]       = from_msg && !mask_scm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      scm_q <= 1'b0;
    end else begin
      sts_q <= sts_set | (sts_q & ~sts_clr);
      scm_q <= from_msg | (scm_q & ~scm_sts_clr);
    end
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_irq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             irq_q[b] <= 1'b0;
      else if (irq_set[b])    irq_q[b] <= 1'b1;
      else if (irq_clr[b])    irq_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_n        <= 1'b1;
      flush_data    <= 1'b0;
      flush_otq     <= 1'b0;
      cpl_err_valid <= 1'b0;
      cpl_err_class <= '0;
      cpl_err_index <= '0;
    end else begin
      serr_n        <= !serr_fire;
      flush_data    <= act && wants_data_flush(kind);
      flush_otq     <= act && wants_queue_flush(kind);
      cpl_err_valid <= act && wants_error_cpl(kind);
      cpl_err_class <= (act && wants_error_cpl(kind)) ? CLS_W'(ABORT_CLS) : '0;
      cpl_err_index <= (act && wants_error_cpl(kind)) ? IDX_W'(ABORT_IDX) : '0;
    end
  end

  assign sts_word = sts_q;
  assign scm_sts  = scm_q;
  assign irq_sts  = irq_q;

endmodule

// File: rtl/master_abort_handler.sv
module master_abort_handler
  import mah_pkg::*;
#(
  parameter int CONV_CLKS = 5,
  parameter int PCIX_CLKS = 7,
  parameter int STS_W     = 16,
  parameter int ABORT_BIT = 13,
  parameter int SERR_BIT  = 14,
  parameter int CLS_W     = 4,
  parameter int IDX_W     = 8,
  parameter int ABORT_CLS = 1,
  parameter int ABORT_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcix_mode,
  input  logic             frame_n,
  input  logic             devsel_n,
  input  logic [1:0]       bus_kind,
  input  logic             msg_valid,
  input  logic [CLS_W-1:0] msg_class,
  input  logic [IDX_W-1:0] msg_index,
  input  logic [1:0]       msg_kind,
  input  logic             serr_enable,
  input  logic             serr_detect_en,
  input  logic             mask_abort,
  input  logic             mask_serr,
  input  logic             mask_scm,
  input  logic [STS_W-1:0] sts_clr,
  input  logic             scm_sts_clr,
  input  logic [3:0]       irq_clr,
  output logic [STS_W-1:0] sts_word,
  output logic             scm_sts,
  output logic [3:0]       irq_sts,
  output logic             serr_n,
  output logic             flush_data,
  output logic             flush_otq,
  output logic             cpl_err_valid,
  output logic [CLS_W-1:0] cpl_err_class,
  output logic [IDX_W-1:0] cpl_err_index
);

  localparam int MAX_CLKS = (CONV_CLKS > PCIX_CLKS) ? CONV_CLKS : PCIX_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);

  // Named internal events, visible to the bound checker.
  logic      bus_abort_evt;
  txn_kind_e bus_abort_kind;
  logic      msg_abort_hit;
  logic      msg_pending;
  txn_kind_e msg_pend_kind;
  logic      msg_served;

  mah_devsel_timer #(
    .CONV_CLKS(CONV_CLKS),
    .PCIX_CLKS(PCIX_CLKS),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcix_mode(pcix_mode),
    .frame_n  (frame_n),
    .devsel_n (devsel_n),
    .kind_i   (txn_kind_e'(bus_kind)),
    .abort_o  (bus_abort_evt),
    .kind_o   (bus_abort_kind)
  );

  mah_msg_filter #(
    .CLS_W    (CLS_W),
    .IDX_W    (IDX_W),
    .ABORT_CLS(ABORT_CLS),
    .ABORT_IDX(ABORT_IDX)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcix_mode(pcix_mode),
    .msg_valid(msg_valid),
    .msg_class(msg_class),
    .msg_index(msg_index),
    .msg_kind (txn_kind_e'(msg_kind)),
    .take_i   (msg_served),
    .hit_o    (msg_abort_hit),
    .pend_o   (msg_pending),
    .kind_o   (msg_pend_kind)
  );

  mah_action #(
    .STS_W    (STS_W),
    .ABORT_BIT(ABORT_BIT),
    .SERR_BIT (SERR_BIT),
    .CLS_W    (CLS_W),
    .IDX_W    (IDX_W),
    .ABORT_CLS(ABORT_CLS),
    .ABORT_IDX(ABORT_IDX)
  ) u_action (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_evt       (bus_abort_evt),
    .bus_kind      (bus_abort_kind),
    .msg_pend      (msg_pending),
    .msg_kind      (msg_pend_kind),
    .msg_take      (msg_served),
    .serr_enable   (serr_enable),
    .serr_detect_en(serr_detect_en),
    .mask_abort    (mask_abort),
    .mask_serr     (mask_serr),
    .mask_scm      (mask_scm),
    .sts_clr       (sts_clr),
    .scm_sts_clr   (scm_sts_clr),
    .irq_clr       (irq_clr),
    .sts_word      (sts_word),
    .scm_sts       (scm_sts),
    .irq_sts       (irq_sts),
    .serr_n        (serr_n),
    .flush_data    (flush_data),
    .flush_otq     (flush_otq),
    .cpl_err_valid (cpl_err_valid),
    .cpl_err_class (cpl_err_class),
    .cpl_err_index (cpl_err_index)
  );

endmodule

// File: rtl/mah_checker.sv
module mah_checker #(
  parameter int STS_W     = 16,
  parameter int ABORT_BIT = 13,
  parameter int SERR_BIT  = 14,
  parameter int CLS_W     = 4,
  parameter int IDX_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             devsel_n,
  input logic             serr_enable,
  input logic             serr_detect_en,
  input logic             mask_abort,
  input logic [STS_W-1:0] sts_clr,
  input logic [STS_W-1:0] sts_word,
  input logic [3:0]       irq_sts,
  input logic             serr_n,
  input logic             flush_data,
  input logic             flush_otq,
  input logic             cpl_err_valid,
  input logic [CLS_W-1:0] cpl_err_class,
  input logic [IDX_W-1:0] cpl_err_index,
  input logic             bus_abort_evt
);

  // R1: a timeout is only raised after DEVSEL# was sampled high
  a_r1_timeout_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort_evt |-> $past(devsel_n));

  // R3: abort status bit survives until written with one
  a_r3_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_word[ABORT_BIT] && !sts_clr[ABORT_BIT]) |=> sts_word[ABORT_BIT]);

  // R4: abort interrupt bit rises only while unmasked
  a_r4_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts[0]) |-> !$past(mask_abort));

  // R5: a data flush always comes with a recorded abort
  a_r5_flush_has_status: assert property (@(posedge clk) disable iff (!rst_n)
    flush_data |-> sts_word[ABORT_BIT]);

  // R7: SERR# pulse needs the enable, sets its status and flushes the write
  a_r7_serr_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> ($past(serr_enable) && sts_word[SERR_BIT] && flush_data));

  // R8: detected bit rises only with the enable and alongside a SERR# pulse
  a_r8_detect_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts[2]) |-> ($past(serr_detect_en) && !serr_n));

  // R10: error completion code and its queue flush
  a_r10_cpl_code: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_err_valid |-> (cpl_err_class == CLS_W'(1) && cpl_err_index == '0 &&
                       flush_otq && !flush_data));

endmodule

bind master_abort_handler mah_checker #(
  .STS_W    (STS_W),
  .ABORT_BIT(ABORT_BIT),
  .SERR_BIT (SERR_BIT),
  .CLS_W    (CLS_W),
  .IDX_W    (IDX_W)
) u_mah_checker (.*);

// File: tb/test_master_abort_handler.sv
module test_master_abort_handler;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pcix_mode = 1'b0;
  logic        frame_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic [1:0]  bus_kind = 2'd0;
  logic        msg_valid = 1'b0;
  logic [3:0]  msg_class = 4'd0;
  logic [7:0]  msg_index = 8'd0;
  logic [1:0]  msg_kind = 2'd0;
  logic        serr_enable = 1'b0;
  logic        serr_detect_en = 1'b0;
  logic        mask_abort = 1'b0;
  logic        mask_serr = 1'b0;
  logic        mask_scm = 1'b0;
  logic [15:0] sts_clr = '0;
  logic        scm_sts_clr = 1'b0;
  logic [3:0]  irq_clr = '0;
  logic [15:0] sts_word;
  logic        scm_sts;
  logic [3:0]  irq_sts;
  logic        serr_n;
  logic        flush_data;
  logic        flush_otq;
  logic        cpl_err_valid;
  logic [3:0]  cpl_err_class;
  logic [7:0]  cpl_err_index;

  int n_checks = 0;
  int n_fail   = 0;
  int n_serr, n_fd, n_fo, n_cpl, bad_cpl, abort_cyc, scm_cyc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  master_abort_handler i_master_abort_handler (.*);

  function automatic int window_of(input logic px);
    if (px) return 7;
    return 5;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic observe(input int j);
    if (!serr_n) n_serr++;
    if (flush_data) n_fd++;
    if (flush_otq) n_fo++;
    if (cpl_err_valid) begin
      n_cpl++;
      if (cpl_err_class != 4'h1 || cpl_err_index != 8'h00) bad_cpl++;
    end
    if (sts_word[13] && abort_cyc < 0) abort_cyc = j;
    if (scm_sts && scm_cyc < 0) scm_cyc = j;
  endtask

  task automatic clear_all();
    sts_clr = '1; scm_sts_clr = 1'b1; irq_clr = '1;
    @(negedge clk);
    sts_clr = '0; scm_sts_clr = 1'b0; irq_clr = '0;
  endtask

  // One bus transaction, with an optional message sampled at edge msg_at.
  // dv = edge where DEVSEL# is first sampled low, 0 for never.
  task automatic run_txn(input string tag, input int kind, input logic px, input int dv,
                         input int msg_at, input int mkind, input int cls, input int idx);
    int  lim, ev_serr, ev_fd, ev_fo, ev_cpl, exp_abort_cyc, exp_scm_cyc, bus_cyc, msg_cyc;
    bit  bus_ab, msg_ok;
    clear_all();
    n_serr = 0; n_fd = 0; n_fo = 0; n_cpl = 0; bad_cpl = 0; abort_cyc = -1; scm_cyc = -1;
    lim    = window_of(px);
    bus_ab = (dv == 0) || (dv > lim);
    msg_ok = (msg_at > 0) && px && (cls == 1) && (idx == 0);
    pcix_mode = px; bus_kind = 2'(kind); frame_n = 1'b0;
    for (int j = 0; j <= lim + 4; j++) begin
      devsel_n  = !((dv != 0) && (j >= dv));
      msg_valid = (msg_at != 0) && (j == msg_at);
      msg_class = 4'(cls); msg_index = 8'(idx); msg_kind = 2'(mkind);
      @(negedge clk);
      observe(j);
    end
    frame_n = 1'b1; devsel_n = 1'b1; msg_valid = 1'b0;
    @(negedge clk);
    ev_serr = 0; ev_fd = 0; ev_fo = 0; ev_cpl = 0;
    bus_cyc = bus_ab ? lim + 1 : -1;
    msg_cyc = -1;
    if (bus_ab) begin
      ev_fd  += (kind != 0); ev_fo += (kind != 3); ev_cpl += (kind == 0);
      ev_serr += (kind == 2 && serr_enable);
    end
    if (msg_ok) begin
      ev_fd  += (mkind != 0); ev_fo += (mkind != 3); ev_cpl += (mkind == 0);
      ev_serr += (mkind == 2 && serr_enable);
      msg_cyc = msg_at + 1 + ((bus_ab && msg_at == lim) ? 1 : 0);
    end
    exp_abort_cyc = bus_cyc;
    if (msg_cyc >= 0 && (exp_abort_cyc < 0 || msg_cyc < exp_abort_cyc)) exp_abort_cyc = msg_cyc;
    exp_scm_cyc = msg_cyc;
    check({tag, " R1"}, "abort clock", abort_cyc, exp_abort_cyc);
    check({tag, " R3"}, "abort status", int'(sts_word[13]), int'(bus_ab || msg_ok));
    check({tag, " R5"}, "data flush pulses", n_fd, ev_fd);
    check({tag, " R6"}, "queue flush pulses", n_fo, ev_fo);
    check({tag, " R7"}, "SERR# pulses", n_serr, ev_serr);
    check({tag, " R7"}, "SERR# status", int'(sts_word[14]), int'(ev_serr > 0));
    check({tag, " R10"}, "error completions", n_cpl, ev_cpl);
    check({tag, " R10"}, "bad completion codes", bad_cpl, 0);
    check({tag, " R4"}, "abort irq", int'(irq_sts[0]), int'((bus_ab || msg_ok) && !mask_abort));
    check({tag, " R8"}, "SERR# asserted irq", int'(irq_sts[1]), int'(ev_serr > 0 && !mask_serr));
    check({tag, " R8"}, "SERR# detected irq", int'(irq_sts[2]), int'(ev_serr > 0 && serr_detect_en));
    check({tag, " R9"}, "message status clock", scm_cyc, exp_scm_cyc);
    check({tag, " R9"}, "message irq", int'(irq_sts[3]), int'(msg_ok && !mask_scm));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20071));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12", "status word", int'(sts_word), 0);
    check("R12", "irq bits", int'(irq_sts), 0);
    check("R12", "serr_n", int'(serr_n), 1);
    check("R12", "pulses", int'({flush_data, flush_otq, cpl_err_valid, scm_sts}), 0);

    // R1: window edges in both modes
    run_txn("conv claim last", 1, 1'b0, 5, 0, 0, 0, 0);
    run_txn("conv late claim", 1, 1'b0, 6, 0, 0, 0, 0);
    run_txn("pcix claim last", 0, 1'b1, 7, 0, 0, 0, 0);
    run_txn("pcix late claim", 0, 1'b1, 8, 0, 0, 0, 0);
    run_txn("conv never", 3, 1'b0, 0, 0, 0, 0, 0);

    // R7 R8: MSI write with SERR# enabled, then masked / disabled variants
    serr_enable = 1'b1; serr_detect_en = 1'b1;
    run_txn("msi serr", 2, 1'b1, 0, 0, 0, 0, 0);
    mask_serr = 1'b1; serr_detect_en = 1'b0;
    run_txn("msi serr masked", 2, 1'b0, 0, 0, 0, 0, 0);
    serr_enable = 1'b0; mask_serr = 1'b0;
    run_txn("msi no enable", 2, 1'b0, 0, 0, 0, 0, 0);

    // R9 R10: bridge message for an outbound read, bus claimed
    run_txn("msg read", 1, 1'b1, 1, 3, 0, 1, 0);
    mask_scm = 1'b1;
    run_txn("msg masked", 1, 1'b1, 1, 2, 3, 1, 0);
    mask_scm = 1'b0;

    // R2: messages that must be ignored
    run_txn("R2 conv msg", 1, 1'b0, 1, 3, 0, 1, 0);
    run_txn("R2 bad class", 1, 1'b1, 1, 3, 0, 2, 0);
    run_txn("R2 bad index", 1, 1'b1, 1, 3, 1, 1, 1);
    check("R2", "message status after ignored codes", int'(scm_sts), 0);

    // R11: timeout and message detected together
    run_txn("R11 tie", 1, 1'b0, 0, 0, 0, 0, 0);
    run_txn("R11 tie pcix", 1, 1'b1, 0, 7, 3, 1, 0);
    check("R11", "two data flushes on tie", n_fd, 2);
    check("R11", "message acted one clock after timeout", scm_cyc - abort_cyc, 1);

    // R4 R3: raising the mask later and partial clears
    mask_abort = 1'b0;
    run_txn("sticky", 0, 1'b0, 0, 0, 0, 0, 0);
    mask_abort = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", "irq kept after late mask", int'(irq_sts[0]), 1);
    irq_clr = 4'b0010;
    @(negedge clk);
    irq_clr = '0;
    check("R4", "irq kept when other bit cleared", int'(irq_sts[0]), 1);
    sts_clr = 16'h0001;
    @(negedge clk);
    sts_clr = '0;
    check("R3", "status kept on clear of other bit", int'(sts_word[13]), 1);
    sts_clr = 16'h2000;
    irq_clr = 4'b0001;
    @(negedge clk);
    sts_clr = '0; irq_clr = '0;
    check("R3", "status cleared by one", int'(sts_word[13]), 0);
    check("R4", "irq cleared by one", int'(irq_sts[0]), 0);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      int  k, dv, mat, mk;
      logic px;
      k   = int'($urandom_range(0, 3));
      px  = 1'($urandom_range(0, 1));
      dv  = int'($urandom_range(0, 9));
      mat = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 6)) : 0;
      mk  = int'($urandom_range(0, 3));
      mask_abort     = 1'($urandom_range(0, 1));
      mask_serr      = 1'($urandom_range(0, 1));
      mask_scm       = 1'($urandom_range(0, 1));
      serr_enable    = 1'($urandom_range(0, 1));
      serr_detect_en = 1'($urandom_range(0, 1));
      run_txn("random", k, px, dv, mat, mk, 1, int'($urandom_range(0, 1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule